// File: doc/BRIEF.md
# Aging-Priority Target Arbiter with Response Watchdog

This block sits in front of one shared target port and decides which of four initiators may use it. Requester 0 is the DSP, 1 the DMA engine, 2 the display controller and 3 the external-bus initiator. Every pending request begins in a low class. Each requester has its own wait counter and its own 8-bit threshold. Once a request has waited as many cycles as its threshold, it counts as urgent. Urgent requests beat all ordinary ones. Inside one class, the choice rotates.

Only one grant is outstanding at a time. After a grant the block waits for the target's response. When a programmable countdown is enabled, it runs while the target stays silent. If it runs out, the grant is withdrawn and a one-cycle abort pulse names the requester that was dropped.

A chip with two such targets uses one instance per target. Thresholds and abort settings are plain configuration inputs. They are meant to be driven from registers whose reset values are: thresholds 0, abort enable 1, abort count 0xFF.

Top module: `aging_arbiter`

## Requirements
- R1: `gnt` has at most one bit set. Once set, it stays unchanged until a response is seen or an abort fires, even if the request is withdrawn.
- R2: While reset is asserted and in the first cycle after it, `gnt` and `abort_pulse` are all zero.
- R3: A grant is issued only from idle. A request present before a clock edge while idle is granted on that edge. After a release the block spends one cycle idle before the next grant.
- R4: Requester i's wait count is the number of clock edges at which it was requesting and not granted. The requester is urgent when this count is greater than or equal to its threshold `thresh_cfg[8*i +: 8]`. A threshold of 0 makes a request urgent at once.
- R5: When any requesting initiator is urgent, the grant goes to an urgent one and never to a non-urgent one.
- R6: Within a class, requesters are served round-robin in rising index order, starting after the last granted index. After reset, requester 0 has first turn.
- R7: A response (`rsp_valid` high while granted) clears `gnt` on the next edge and produces no abort. This holds even when the abort count expires on that same edge.
- R8: At each grant the abort count L is loaded. If no response arrives, then on the (L+1)-th edge after the grant edge `gnt` clears and `abort_pulse` carries the dropped requester's bit for exactly one cycle.
- R9: With `abort_en` at 0, a grant without response is held indefinitely and no abort is issued.
- R10: Withdrawing a request clears its wait count, so a re-raised request starts aging from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Request per initiator (0 DSP, 1 DMA, 2 display, 3 external bus) |
| rsp_valid | input | 1 | Target response for the outstanding grant |
| thresh_cfg | input | 32 | Promotion thresholds, 8 bits per requester, requester i at bits 8*i+7..8*i |
| abort_en | input | 1 | 1 enables the response watchdog |
| abort_cnt | input | 8 | Watchdog load value L |
| gnt | output | 4 | One-hot grant, held while outstanding |
| abort_pulse | output | 4 | One-cycle pulse with the aborted requester's bit |

## Verification
The bench builds the block with its default parameters: four requesters and 8-bit counters. Because thresholds and the abort count are run-time inputs, it can choose values as small as 0, 2, 3 or 255. These small values make the exact promotion boundary reachable: a wait of two edges against thresholds 2 and 3. They also make the zero-threshold case, the abort after exactly L+1 silent edges, and the race where response and expiry fall on the same edge reachable within a few cycles.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arb_state_e;
endpackage

// File: rtl/arb_wait_counter.sv
// Per-requester aging counter and urgency flag.
module arb_wait_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             granted,
  input  logic [CNT_W-1:0] thresh,
  output logic             urgent
);
  logic [CNT_W-1:0] wait_q;

  // Saturating increment while pending; clear when withdrawn or granted.
  function automatic logic [CNT_W-1:0] next_wait(input logic pend,
                                                 input logic [CNT_W-1:0] cur);
    if (!pend) return '0;
    if (&cur) return cur;
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= next_wait(req && !granted, wait_q);
  end

  assign urgent = req && (wait_q >= thresh);
endmodule

// File: rtl/arb_rr_pick.sv
// Rotating selection: first candidate after index 'last'.
module arb_rr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] last,
  output logic [N-1:0]     pick,
  output logic [IDX_W-1:0] pick_idx,
  output logic             found
);
  function automatic int first_after(input logic [N-1:0] c, input int from);
    for (int k = 1; k <= N; k++) begin
      if (c[(from + k) % N]) return (from + k) % N;
    end
    return -1;
  endfunction

  int sel;

  always_comb begin
    sel      = first_after(cand, int'(last));
    found    = (sel >= 0);
    pick     = '0;
    pick_idx = '0;
    if (sel >= 0) begin
      pick[sel] = 1'b1;
      pick_idx  = IDX_W'(sel);
    end
  end
endmodule

// File: rtl/arb_abort_timer.sv
// Countdown watchdog for the outstanding grant.
module arb_abort_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  input  logic             rsp,
  input  logic             en,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] left_q;
  logic             silent;

  assign silent = active && !rsp && en;

  always_ff @(posedge clk) begin
    if (!rst_n)                     left_q <= '1;
    else if (load)                  left_q <= load_val;
    else if (silent && left_q != 0) left_q <= left_q - 1'b1;
  end

  assign expire = silent && (left_q == '0);
endmodule

// File: rtl/aging_arbiter.sv
module aging_arbiter #(
  parameter int N_REQ = 4,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REQ-1:0]       req,
  input  logic                   rsp_valid,
  input  logic [N_REQ*CNT_W-1:0] thresh_cfg,
  input  logic                   abort_en,
  input  logic [CNT_W-1:0]       abort_cnt,
  output logic [N_REQ-1:0]       gnt,
  output logic [N_REQ-1:0]       abort_pulse
);
  import arb_pkg::*;

  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  arb_state_e       state_q;
  logic [N_REQ-1:0] gnt_q;
  logic [N_REQ-1:0] abort_q;
  logic [IDX_W-1:0] last_q;

  // Named internal events, also watched by the checker.
  logic [N_REQ-1:0] hi_vec;
  logic [N_REQ-1:0] cand;
  logic [N_REQ-1:0] pick;
  logic [IDX_W-1:0] pick_idx;
  logic             found;
  logic             grant_fire;
  logic             rsp_fire;
  logic             abort_fire;
  logic             busy;

  assign busy = (state_q == ST_BUSY);

  for (genvar i = 0; i < N_REQ; i++) begin : g_age
    arb_wait_counter #(.CNT_W(CNT_W)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req[i]),
      .granted (gnt_q[i]),
      .thresh  (thresh_cfg[i*CNT_W +: CNT_W]),
      .urgent  (hi_vec[i])
    );
  end

  assign cand = (|hi_vec) ? hi_vec : req;

  arb_rr_pick #(.N(N_REQ), .IDX_W(IDX_W)) u_pick (
    .cand     (cand),
    .last     (last_q),
    .pick     (pick),
    .pick_idx (pick_idx),
    .found    (found)
  );

  assign grant_fire = !busy && found;
  assign rsp_fire   = busy && rsp_valid;

  arb_abort_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (grant_fire),
    .active   (busy),
    .rsp      (rsp_valid),
    .en       (abort_en),
    .load_val (abort_cnt),
    .expire   (abort_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      abort_q <= '0;
      last_q  <= IDX_W'(N_REQ - 1);
    end else begin
      abort_q <= '0;
      if (!busy) begin
        if (grant_fire) begin
          gnt_q   <= pick;
          last_q  <= pick_idx;
          state_q <= ST_BUSY;
        end
      end else if (rsp_fire || abort_fire) begin
        gnt_q   <= '0;
        state_q <= ST_IDLE;
        if (abort_fire) abort_q <= gnt_q;
      end
    end
  end

  assign gnt         = gnt_q;
  assign abort_pulse = abort_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N_REQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] req,
  input logic             rsp_valid,
  input logic             abort_en,
  input logic [N_REQ-1:0] gnt,
  input logic [N_REQ-1:0] abort_pulse,
  input logic [N_REQ-1:0] hi_vec,
  input logic             abort_fire
);
  p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_grant_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 0 && !rsp_valid && !abort_fire) |=> (gnt == $past(gnt)));

  p_grant_from_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 0 && $past(gnt) == 0) |-> (($past(req) & gnt) != 0));

  p_urgent_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 0 && $past(gnt) == 0) |->
      ($past(hi_vec) == 0 || ($past(hi_vec) & gnt) != 0));

  p_rsp_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 0 && rsp_valid) |=> (gnt == 0 && abort_pulse == 0));

  p_abort_names_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse != 0) |-> (gnt == 0 && $past(gnt) == abort_pulse));

  p_abort_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse != 0) |=> (abort_pulse == 0));

  p_abort_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse != 0) |-> $past(abort_en));
endmodule

bind aging_arbiter arb_checker #(.N_REQ(N_REQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .rsp_valid   (rsp_valid),
  .abort_en    (abort_en),
  .gnt         (gnt),
  .abort_pulse (abort_pulse),
  .hi_vec      (hi_vec),
  .abort_fire  (abort_fire)
);

// File: tb/tb_aging_arbiter.sv
`timescale 1ns/1ps
module tb_aging_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req;
  logic        rsp_valid;
  logic [31:0] thresh_cfg;
  logic        abort_en;
  logic [7:0]  abort_cnt;
  logic [3:0]  gnt;
  logic [3:0]  abort_pulse;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  aging_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req(req), .rsp_valid(rsp_valid),
    .thresh_cfg(thresh_cfg), .abort_en(abort_en), .abort_cnt(abort_cnt),
    .gnt(gnt), .abort_pulse(abort_pulse)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_thr(input int i, input logic [7:0] v);
    thresh_cfg[i*8 +: 8] = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; rsp_valid = 1'b0;
    thresh_cfg = {4{8'hFF}}; abort_en = 1'b1; abort_cnt = 8'hFF;
    repeat (3) tick();
    chk(gnt, 4'b0, "R2 grant in reset");
    chk(abort_pulse, 4'b0, "R2 abort in reset");
    rst_n = 1'b1;
    tick();
    chk(gnt, 4'b0, "R2 grant after reset");
    chk(abort_pulse, 4'b0, "R2 abort after reset");
  endtask

  task automatic release_grant();
    rsp_valid = 1'b1; req = '0;
    tick();
    rsp_valid = 1'b0;
    tick();
  endtask

  // R3/R7: single request granted on the next edge, response releases.
  task automatic t_single();
    do_reset();
    req = 4'b0100;
    tick();
    chk(gnt, 4'b0100, "R3 single grant timing");
    req = 4'b0000;
    tick();
    chk(gnt, 4'b0100, "R1 grant held after withdrawal");
    rsp_valid = 1'b1;
    tick();
    chk(gnt, 4'b0000, "R7 response releases");
    chk(abort_pulse, 4'b0000, "R7 no abort on response");
    rsp_valid = 1'b0;
  endtask

  // R6: rotation among ordinary requests, requester 0 first after reset.
  task automatic t_round_robin();
    do_reset();
    req = 4'b1111;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(gnt, 4'(1 << (k % 4)), "R6 rotation order");
      rsp_valid = 1'b1;
      tick();
      chk(gnt, 4'b0000, "R3 idle cycle after release");
      rsp_valid = 1'b0;
    end
    req = '0;
    tick();
  endtask

  // R4/R5: requester 2 waits exactly two edges before arbitration.
  task automatic t_promote(input logic [7:0] thr2, input logic [3:0] exp, input string tag);
    do_reset();
    set_thr(2, thr2);
    req = 4'b1000;
    tick();
    chk(gnt, 4'b1000, "R3 blocker grant");
    req = 4'b1101;
    tick();
    rsp_valid = 1'b1; req = 4'b0101;
    tick();
    rsp_valid = 1'b0;
    tick();
    chk(gnt, exp, tag);
    release_grant();
  endtask

  // R4: threshold 0 is urgent immediately and overrides rotation.
  task automatic t_zero_thr();
    do_reset();
    set_thr(2, 8'd0);
    req = 4'b0101;
    tick();
    chk(gnt, 4'b0100, "R4 zero threshold urgent at once");
    release_grant();
  endtask

  // R10: withdrawal restarts aging.
  task automatic t_withdraw();
    do_reset();
    set_thr(3, 8'd3);
    req = 4'b0001;
    tick();
    chk(gnt, 4'b0001, "R3 blocker grant");
    req = 4'b1011;
    repeat (5) tick();
    req = 4'b0011;
    tick();
    req = 4'b1010; rsp_valid = 1'b1;
    tick();
    rsp_valid = 1'b0;
    tick();
    chk(gnt, 4'b0010, "R10 withdrawn request restarts aging");
    release_grant();
  endtask

  // R8: abort after L+1 silent edges with L=3.
  task automatic t_abort();
    do_reset();
    abort_cnt = 8'd3;
    req = 4'b0010;
    tick();
    chk(gnt, 4'b0010, "R8 grant before abort");
    req = 4'b0000;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(gnt, 4'b0010, "R8 grant held while counting");
      chk(abort_pulse, 4'b0000, "R8 no early abort");
    end
    tick();
    chk(abort_pulse, 4'b0010, "R8 abort names requester");
    chk(gnt, 4'b0000, "R8 grant dropped on abort");
    tick();
    chk(abort_pulse, 4'b0000, "R8 abort lasts one cycle");
  endtask

  // R7: response wins when expiry falls on the same edge (L=0).
  task automatic t_race();
    do_reset();
    abort_cnt = 8'd0;
    req = 4'b0100;
    tick();
    chk(gnt, 4'b0100, "R7 grant before race");
    rsp_valid = 1'b1; req = 4'b0000;
    tick();
    chk(gnt, 4'b0000, "R7 released in race");
    chk(abort_pulse, 4'b0000, "R7 response beats expiry");
    rsp_valid = 1'b0;
    tick();
    chk(abort_pulse, 4'b0000, "R7 no late abort");
  endtask

  // R9: disabled watchdog never aborts.
  task automatic t_disabled();
    do_reset();
    abort_en = 1'b0; abort_cnt = 8'd2;
    req = 4'b0001;
    tick();
    req = 4'b0000;
    for (int k = 0; k < 20; k++) begin
      tick();
      chk(gnt, 4'b0001, "R9 grant held with watchdog off");
      chk(abort_pulse, 4'b0000, "R9 no abort with watchdog off");
    end
    release_grant();
    abort_en = 1'b1;
  endtask

  initial begin
    t_single();
    t_round_robin();
    t_promote(8'd2, 4'b0100, "R4 R5 threshold met, urgent wins");
    t_promote(8'd3, 4'b0001, "R4 threshold one short, rotation wins");
    t_zero_thr();
    t_withdraw();
    t_abort();
    t_race();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule